// File: doc/BRIEF.md
# I2C Target Port with Event Status

This block is the target (slave) side of an I2C bus, set up and serviced by a local host through a small register bus. It answers one 7-bit own address. It can also answer the general-call address. Each bus event raises a bit in a status register, and a matching enable register decides which bits drive the interrupt line. A single data register carries received bytes to the host and carries the bytes the host wants to send onto the bus.

The host never has to meet the bus timing. When the target has received a byte the host has not yet taken, or needs a byte the host has not yet supplied, it holds SCL low after the acknowledge bit. It lets SCL go when the host clears the matching status bit. Status bits are cleared by writing zero to them, so one write can clear any chosen subset.

Top module: `i2ct_target`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Register map on `reg_addr`: 0 control, 1 status, 2 interrupt enable, 3 own address (7 bits), 4 data. Control bit 0 forces NACK, bit 1 enables the general call, bit 2 enables the target, and bit 3 is a stored buffer-select bit. Written values read back. Reads have no side effect on any register.
- R3: A write-direction address byte whose upper 7 bits equal a nonzero own address is acknowledged by driving SDA low through the ninth clock. The match sets status bit 0 and copies the R/W bit into status bit 5. Any other address is not acknowledged and sets no match bit.
- R4: In write direction, each byte received (MSB first) is placed in the data register and sets status bit 1. SCL is held low after that byte's acknowledge bit until bit 1 is cleared.
- R5: While control bit 0 is set, received data bytes are not acknowledged, but the address byte still is. The bit keeps its value until the host rewrites it.
- R6: A read-direction match sets status bits 5 and 3 and holds SCL low until bit 3 is cleared. The data register is then shifted out MSB first. Each sent byte sets status bit 2. If the controller acknowledges, bit 3 is set again. After a NACK the target releases the bus.
- R7: Status bit 4 is set by every STOP seen while the target is enabled, including STOPs that end traffic for other addresses.
- R8: The address byte 0x00 is acknowledged only while control bit 1 is set. When it is, it sets status bits 0 and 6.
- R9: An own address of zero never matches, in either direction.
- R10: A host write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A bus event in the same cycle takes priority.
- R11: `irq` is high exactly when some status bit and its enable bit (same position in register 2) are both 1.
- R12: With control bit 2 clear, the target drives neither line and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a single, well-behaved controller on the bus. It changes SDA only while SCL is low, except when it makes START or STOP, and it never does that while the target is pulling SDA low. Each line level must also stay put for well over the synchronizer latency. The bench's controller model follows these rules: it holds every SCL phase for ten clocks and moves SDA only after it has pulled SCL low. The scoreboard services the stretch points only through the register bus, so the bench also exercises the release of SCL that the host's flag clear brings about.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int STAT_W = 7;
    localparam int CTRL_W = 4;

    localparam int SB_MATCH = 0;
    localparam int SB_RXD   = 1;
    localparam int SB_TXD   = 2;
    localparam int SB_TXE   = 3;
    localparam int SB_STOP  = 4;
    localparam int SB_DIR   = 5;
    localparam int SB_GC    = 6;

    localparam int CB_FNACK = 0;
    localparam int CB_GCEN  = 1;
    localparam int CB_EN    = 2;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_IEN  = 3'd2;
    localparam logic [2:0] RA_OWN  = 3'd3;
    localparam logic [2:0] RA_DATA = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RXW, ST_RXB, ST_RACK, ST_TXW, ST_TXB, ST_TACK
    } eng_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    input  logic          fnack,
    input  logic          rx_pend,
    input  logic          tx_pend,
    input  logic [DW-1:0] tx_byte,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    output logic          ev_match,
    output logic          ev_gc,
    output logic          ev_dir,
    output logic          ev_rx,
    output logic          ev_txd,
    output logic          ev_txe,
    output logic          ev_stop,
    output logic [DW-1:0] rx_byte,
    output logic          scl_oe,
    output logic          sda_oe
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          rw;
        logic          ack;
    } eng_t;

    eng_t q, d;
    logic own_hit, gc_hit;

    assign own_hit = (own_addr != '0) && (q.sh[DW-1:1] == own_addr);
    assign gc_hit  = gc_en && (q.sh == '0);

    always_comb begin
        d        = q;
        ev_match = 1'b0;
        ev_gc    = 1'b0;
        ev_rx    = 1'b0;
        ev_txd   = 1'b0;
        ev_txe   = 1'b0;
        ev_stop  = 1'b0;
        ev_dir   = q.sh[0];
        rx_byte  = q.sh;
        if (!en) begin
            d = '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, ack: 1'b0};
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            ev_stop = 1'b1;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RXB: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + CW'(1);
                    end else if (scl_fall && q.cnt == CW'(DW)) begin
                        if (q.st == ST_RXB) begin
                            ev_rx = 1'b1;
                            d.ack = ~fnack;
                            d.st  = ST_RACK;
                        end else if (own_hit || gc_hit) begin
                            ev_match = 1'b1;
                            ev_gc    = gc_hit;
                            d.rw     = q.sh[0];
                            d.st     = ST_AACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: if (scl_fall) begin
                    d.st   = q.rw ? ST_TXW : ST_RXW;
                    ev_txe = q.rw;
                end
                ST_RACK: if (scl_fall) d.st = ST_RXW;
                ST_RXW: if (!rx_pend) begin
                    d.st  = ST_RXB;
                    d.cnt = '0;
                end
                ST_TXW: if (!tx_pend) begin
                    d.st  = ST_TXB;
                    d.sh  = tx_byte;
                    d.cnt = '0;
                end
                ST_TXB: if (scl_fall) begin
                    d.sh  = {q.sh[DW-2:0], 1'b1};
                    d.cnt = q.cnt + CW'(1);
                    if (q.cnt == CW'(DW - 1)) d.st = ST_TACK;
                end
                ST_TACK: begin
                    if (scl_rise) d.ack = ~sda_s;
                    else if (scl_fall) begin
                        ev_txd = 1'b1;
                        ev_txe = q.ack;
                        d.st   = q.ack ? ST_TXW : ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, ack: 1'b0};
        else        q <= d;
    end

    assign sda_oe = (q.st == ST_AACK) || (q.st == ST_RACK && q.ack) ||
                    (q.st == ST_TXB && !q.sh[DW-1]);
    assign scl_oe = (q.st == ST_RXW && rx_pend) || (q.st == ST_TXW && tx_pend);

    // R3: the target moves SDA only while SCL is low
    p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R6: once the host clears the empty flag, the byte is loaded at once
    p_tx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.st == ST_TXW && !tx_pend && !stop_det && !start_det) |=> (q.st == ST_TXB));
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          irq
);
    localparam int AW = DW - 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
        logic [AW-1:0]     own;
        logic [DW-1:0]     data;
    } regs_t;

    regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ev_match, ev_gc, ev_dir, ev_rx, ev_txd, ev_txe, ev_stop;
    logic [DW-1:0] rx_byte;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(q.ctrl[CB_EN]), .own_addr(q.own),
        .gc_en(q.ctrl[CB_GCEN]), .fnack(q.ctrl[CB_FNACK]),
        .rx_pend(q.stat[SB_RXD]), .tx_pend(q.stat[SB_TXE]), .tx_byte(q.data),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .ev_match(ev_match), .ev_gc(ev_gc), .ev_dir(ev_dir), .ev_rx(ev_rx),
        .ev_txd(ev_txd), .ev_txe(ev_txe), .ev_stop(ev_stop), .rx_byte(rx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: d.ctrl = reg_wdata[CTRL_W-1:0];
                RA_STAT: d.stat = q.stat & reg_wdata[STAT_W-1:0];
                RA_IEN:  d.ien  = reg_wdata[STAT_W-1:0];
                RA_OWN:  d.own  = reg_wdata[AW-1:0];
                RA_DATA: d.data = reg_wdata;
                default: ;
            endcase
        end
        if (ev_match) begin
            d.stat[SB_MATCH] = 1'b1;
            d.stat[SB_DIR]   = ev_dir;
        end
        if (ev_gc)   d.stat[SB_GC]   = 1'b1;
        if (ev_rx)   d.stat[SB_RXD]  = 1'b1;
        if (ev_txd)  d.stat[SB_TXD]  = 1'b1;
        if (ev_txe)  d.stat[SB_TXE]  = 1'b1;
        if (ev_stop) d.stat[SB_STOP] = 1'b1;
        if (ev_rx)   d.data = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = DW'(q.ctrl);
            RA_STAT: reg_rdata = DW'(q.stat);
            RA_IEN:  reg_rdata = DW'(q.ien);
            RA_OWN:  reg_rdata = DW'(q.own);
            RA_DATA: reg_rdata = q.data;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(q.stat & q.ien);

    // R12: a disabled target leaves both lines alone
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl[CB_EN] |=> (!scl_oe && !sda_oe));

    // R5: a forced NACK keeps SDA released in the acknowledge slot
    p_fnack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && q.ctrl[CB_FNACK]) |=> !sda_oe);

    // R9: with own address zero and general call off, nothing matches
    p_zero_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.own == '0 && !q.ctrl[CB_GCEN]) |-> !ev_match);

    // R10: writing all zeros to status with no event clears it
    p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_STAT && reg_wdata[STAT_W-1:0] == '0 &&
         !(ev_match || ev_rx || ev_txd || ev_txe || ev_stop)) |=> (q.stat == '0));

    // R4: a completed byte is always flagged to the host
    p_rx_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> q.stat[SB_RXD]);
endmodule

// File: tb/i2ct_target_test.sv
module i2ct_target_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    wire        scl_line = m_scl & ~scl_oe;
    wire        sda_line = m_sda & ~sda_oe;

    i2ct_target uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
        .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    localparam int QTR = 10;
    int checks = 0;
    int errors = 0;
    bit svc_on = 1'b0;
    bit bus_lock = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] tx_q[$];

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        while (bus_lock) @(negedge clk);
        bus_lock  = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        bus_lock  = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        while (bus_lock) @(negedge clk);
        bus_lock = 1'b1;
        reg_addr = a;
        #1 v = reg_rdata;
        bus_lock = 1'b0;
    endtask

    task automatic qw();
        repeat (QTR) @(posedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; wait (scl_line === 1'b1); qw();
        m_sda = 1'b1; qw(); qw();
    endtask

    task automatic m_wbit(input logic b);
        m_sda = b; qw();
        m_scl = 1'b1; wait (scl_line === 1'b1); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; wait (scl_line === 1'b1);
        repeat (QTR / 2) @(negedge clk);
        b = sda_line;
        repeat (QTR / 2) @(posedge clk);
        m_scl = 1'b0; qw();
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            v[i] = b;
        end
        m_wbit(~ack);
    endtask

    // scoreboard monitor: services the target as a host would and
    // compares every received byte with the queue the driver filled
    initial begin
        logic [7:0] s, v;
        forever begin
            @(negedge clk);
            if (svc_on && irq) begin
                reg_read(3'd1, s);
                if (s[1]) begin
                    reg_read(3'd4, v);
                    if (exp_q.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R4 unexpected byte actual=%h expected=none", v);
                    end else begin
                        check("R4 received byte", v, exp_q.pop_front());
                    end
                    reg_write(3'd1, 8'hFD);
                end
                if (s[3]) begin
                    if (tx_q.size() > 0) reg_write(3'd4, tx_q.pop_front());
                    reg_write(3'd1, 8'hF7);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, s;
        logic ack;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        for (int a = 0; a < 5; a++) begin
            reg_read(3'(a), v);
            check("R1 register after reset", v, 8'h00);
        end
        check("R1 pins and irq after reset", {5'b0, scl_oe, sda_oe, irq}, 8'h00);

        reg_write(3'd3, 8'h2A);
        reg_write(3'd0, 8'h0C);
        reg_write(3'd2, 8'h0A);
        reg_read(3'd0, v); check("R2 control readback", v, 8'h0C);
        reg_read(3'd3, v); check("R2 own address readback", v, 8'h2A);
        reg_read(3'd2, v); check("R2 enable readback", v, 8'h0A);
        svc_on = 1'b1;

        // write transfer to own address
        exp_q.push_back(8'h5A);
        exp_q.push_back(8'hC3);
        m_start();
        m_wbyte(8'h54, ack); check("R3 address ack", {7'b0, ack}, 8'h01);
        m_wbyte(8'h5A, ack); check("R4 data ack", {7'b0, ack}, 8'h01);
        m_wbyte(8'hC3, ack); check("R4 data ack", {7'b0, ack}, 8'h01);
        m_stop();
        repeat (20) @(negedge clk);
        check("R4 all bytes delivered", 8'(exp_q.size()), 8'h00);
        reg_read(3'd1, s); check("R3 R7 status after write", s, 8'h11);
        reg_read(3'd4, v); check("R2 data read", v, 8'hC3);
        reg_read(3'd4, v); check("R2 data read repeat", v, 8'hC3);
        reg_read(3'd1, s); check("R2 status unchanged by reads", s, 8'h11);
        reg_write(3'd1, 8'hEF);
        reg_read(3'd1, s); check("R10 selective clear", s, 8'h01);
        reg_write(3'd1, 8'h00);
        reg_read(3'd1, s); check("R10 full clear", s, 8'h00);

        // forced NACK
        reg_write(3'd0, 8'h0D);
        exp_q.push_back(8'h11);
        m_start();
        m_wbyte(8'h54, ack); check("R5 address still acked", {7'b0, ack}, 8'h01);
        m_wbyte(8'h11, ack); check("R5 data not acked", {7'b0, ack}, 8'h00);
        m_stop();
        repeat (20) @(negedge clk);
        check("R5 byte still delivered", 8'(exp_q.size()), 8'h00);
        reg_read(3'd0, v); check("R5 force bit sticky", v, 8'h0D);
        reg_write(3'd0, 8'h0C);
        reg_write(3'd1, 8'h00);

        // read transfer
        tx_q.push_back(8'hA5);
        tx_q.push_back(8'h3C);
        m_start();
        m_wbyte(8'h55, ack); check("R6 read address ack", {7'b0, ack}, 8'h01);
        m_rbyte(v, 1'b1); check("R6 first byte", v, 8'hA5);
        m_rbyte(v, 1'b0); check("R6 second byte", v, 8'h3C);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R6 status after read", s, 8'h35);
        check("R6 lines released", {6'b0, scl_oe, sda_oe}, 8'h00);
        reg_write(3'd1, 8'h00);

        // other address, STOP still reported
        m_start();
        m_wbyte(8'h22, ack); check("R3 foreign address not acked", {7'b0, ack}, 8'h00);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R7 stop for other target", s, 8'h10);

        // interrupt masking
        svc_on = 1'b0;
        reg_write(3'd2, 8'h10);
        check("R11 irq with enabled bit", {7'b0, irq}, 8'h01);
        reg_write(3'd2, 8'h01);
        check("R11 irq masked", {7'b0, irq}, 8'h00);
        reg_write(3'd2, 8'h0A);
        reg_write(3'd1, 8'h00);
        svc_on = 1'b1;

        // general call
        m_start();
        m_wbyte(8'h00, ack); check("R8 general call off", {7'b0, ack}, 8'h00);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R8 no match when off", s, 8'h10);
        reg_write(3'd1, 8'h00);
        reg_write(3'd0, 8'h0E);
        exp_q.push_back(8'h77);
        m_start();
        m_wbyte(8'h00, ack); check("R8 general call acked", {7'b0, ack}, 8'h01);
        m_wbyte(8'h77, ack); check("R8 general call data", {7'b0, ack}, 8'h01);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R8 status after general call", s, 8'h51);
        reg_write(3'd0, 8'h0C);
        reg_write(3'd1, 8'h00);

        // own address zero
        reg_write(3'd3, 8'h00);
        m_start();
        m_wbyte(8'h01, ack); check("R9 zero address not acked", {7'b0, ack}, 8'h00);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R9 no match", s, 8'h10);
        reg_write(3'd3, 8'h2A);
        reg_write(3'd1, 8'h00);

        // disabled target
        reg_write(3'd0, 8'h08);
        m_start();
        m_wbyte(8'h54, ack); check("R12 disabled no ack", {7'b0, ack}, 8'h00);
        m_stop();
        repeat (20) @(negedge clk);
        reg_read(3'd1, s); check("R12 disabled no flags", s, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule